// File: doc/BRIEF.md
# Clock and Reset Status Flag Register

This block is the one-byte status and event register of a clock, reset and power management unit. It latches sticky flags for three reset causes (power-on, low-voltage and illegal-address), for the end of each periodic timer interval, and for any change in the PLL lock level or in the oscillator-qualified level. It also shows the live, synchronized values of those two levels. Software reads the whole byte on `rdData` and clears flags by writing ones to them. Writing zeros, or writing to the status bits, changes nothing.

The lock and oscillator inputs are asynchronous levels. Each passes through a synchronizer chain of parameterized depth before its change is detected. A warm-up counter holds off change detection until the history register contains a real synchronized value, so a status that is already high when reset ends does not raise a flag. A pulse on `fullStopEntry` forces the visible oscillator status low. It stays low until the synchronized oscillator input has been seen low, and the forced drop counts as a change. Three interrupt request outputs each combine one flag with its own enable.

The power-on-reset flag is preset by the asynchronous power-on reset. The system reset `rstN` does not touch it, and `rstN` clears every other flag.

Top module: `clkrst_status_reg`

## Requirements
- R1: Right after a power-on reset with all inputs low, `rdData` reads 8'h40 and all three interrupt outputs are 0.
- R2: Flag bits 7, 6, 5, 4, 2 and 1 are cleared only by a write with a 1 in that bit position. A 0 in a bit position leaves that flag unchanged.
- R3: Bit 3 shows the synchronized lock level and bit 0 shows the visible oscillator-qualified level. Writes of any value leave both bits unchanged.
- R4: Any change of the synchronized lock level, rising or falling, sets bit 4 on the next clock edge. With the default two-stage synchronizer, a lock input change sampled at edge k shows in bit 3 after edge k+1 and sets bit 4 at edge k+2.
- R5: Any change of the visible oscillator-qualified level, rising or falling, sets bit 1. It follows the same cycle timing as R4.
- R6: A one-cycle `tmrTick` pulse sets bit 7. `tmrIrq` is high exactly when bit 7 is 1 and `tmrIrqEn` is 1.
- R7: `lockIrq` equals bit 4 AND `lockIrqEn`. `oscIrq` equals bit 1 AND `oscIrqEn`.
- R8: A `fullStopEntry` pulse forces bit 0 low from the next edge onward, which sets bit 1 if bit 0 was high. Bit 0 stays low while the oscillator input stays high, and it can rise again only after the synchronized oscillator input has been seen low.
- R9: A `lvrEvt` pulse sets bit 5 and an `ilaEvt` pulse sets bit 2.
- R10: When a set event and a write-1 clear of the same flag fall on the same clock edge, the flag ends up set.
- R11: After any reset, lock or oscillator levels that are already high appear in bits 3 and 0 without setting bit 4 or bit 1.
- R12: Asserting `porRstN` sets bit 6. Asserting only `rstN` clears the other flags and leaves bit 6 at its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low; presets bit 6 and resets all other state |
| rstN | input | 1 | Asynchronous system reset, active low; does not affect bit 6 |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data; a 1 clears the matching flag |
| rdData | output | 8 | Register read value |
| tmrTick | input | 1 | One-cycle pulse at the end of each timer period |
| lvrEvt | input | 1 | Low-voltage reset event pulse |
| ilaEvt | input | 1 | Illegal-address reset event pulse |
| lockIn | input | 1 | Asynchronous PLL lock level |
| oscIn | input | 1 | Asynchronous oscillator-qualified level |
| fullStopEntry | input | 1 | Pulse marking entry into full stop mode |
| tmrIrqEn | input | 1 | Enable for the timer interrupt |
| lockIrqEn | input | 1 | Enable for the lock-change interrupt |
| oscIrqEn | input | 1 | Enable for the oscillator-change interrupt |
| tmrIrq | output | 1 | Timer interrupt request |
| lockIrq | output | 1 | Lock-change interrupt request |
| oscIrq | output | 1 | Oscillator-change interrupt request |

## Verification
A hardware set event and a software write-1 clear can reach the same flag on the same clock edge. The bench provokes this by first setting the timer flag, then driving `tmrTick` high in the same cycle as a write of 8'h80. It judges the result by reading back that bit 7 is still set, and then checks that a plain write of 8'h80 does clear it. A second overlap also gets its own scenario: a full-stop entry while the oscillator is qualified both forces the status low and raises the oscillator-change flag.

// File: rtl/clkrst_flag_pkg.sv
package clkrst_flag_pkg;

  localparam int REG_W    = 8;

  // Bit positions; software decodes these, so they are fixed.
  localparam int BIT_TMR  = 7;
  localparam int BIT_POR  = 6;
  localparam int BIT_LVR  = 5;
  localparam int BIT_LCHG = 4;
  localparam int BIT_LOCK = 3;
  localparam int BIT_ILA  = 2;
  localparam int BIT_OCHG = 1;
  localparam int BIT_OSC  = 0;

  // Sticky flags (write-1-to-clear); the remaining bits are live status.
  localparam logic [REG_W-1:0] FLAG_MASK = (REG_W'(1) << BIT_TMR)  |
                                           (REG_W'(1) << BIT_POR)  |
                                           (REG_W'(1) << BIT_LVR)  |
                                           (REG_W'(1) << BIT_LCHG) |
                                           (REG_W'(1) << BIT_ILA)  |
                                           (REG_W'(1) << BIT_OCHG);

  // Strobes from control to datapath.
  typedef struct packed {
    logic [REG_W-1:0] setMask;
    logic [REG_W-1:0] clrMask;
    logic             lockLvl;
    logic             oscLvl;
  } flagCtl_t;

endpackage

// File: rtl/status_sync.sv
module status_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/clkrst_flag_ctrl.sv
module clkrst_flag_ctrl
  import clkrst_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             tmrTick,
  input  logic             lvrEvt,
  input  logic             ilaEvt,
  input  logic             lockIn,
  input  logic             oscIn,
  input  logic             fullStopEntry,
  output flagCtl_t         ctl
);

  localparam int N_CH     = 2;             // channel 1: lock, channel 0: oscillator
  localparam int WARM_CNT = SYNC_STAGES + 1;
  localparam int CNT_W    = $clog2(WARM_CNT + 1);

  logic [N_CH-1:0]  rawIn;
  logic [N_CH-1:0]  syncd;
  logic [N_CH-1:0]  vis;
  logic [N_CH-1:0]  prevVis;
  logic [N_CH-1:0]  chg;
  logic [CNT_W-1:0] warmCnt;
  logic             warm;
  logic             stopHold;

  assign rawIn = {lockIn, oscIn};

  for (genvar c = 0; c < N_CH; c++) begin : gSync
    status_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .din  (rawIn[c]),
      .dout (syncd[c])
    );
  end

  // Hold off change detection until the history holds a real synchronized value.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          warmCnt <= '0;
    else if (warmCnt != CNT_W'(WARM_CNT)) warmCnt <= warmCnt + 1'b1;
  end
  assign warm = (warmCnt == CNT_W'(WARM_CNT));

  // Full stop forces the oscillator status low until the input is seen low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              stopHold <= 1'b0;
    else if (fullStopEntry) stopHold <= 1'b1;
    else if (!syncd[0])     stopHold <= 1'b0;
  end

  assign vis[1] = syncd[1];
  assign vis[0] = syncd[0] & ~stopHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVis <= '0;
    else       prevVis <= vis;
  end

  assign chg = warm ? (vis ^ prevVis) : '0;

  always_comb begin
    ctl          = '0;
    ctl.setMask[BIT_TMR]  = tmrTick;
    ctl.setMask[BIT_LVR]  = lvrEvt;
    ctl.setMask[BIT_ILA]  = ilaEvt;
    ctl.setMask[BIT_LCHG] = chg[1];
    ctl.setMask[BIT_OCHG] = chg[0];
    ctl.clrMask           = wrEn ? (wrData & FLAG_MASK) : '0;
    ctl.lockLvl           = vis[1];
    ctl.oscLvl            = vis[0];
  end

  AST_LOCK_CHG: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !$stable(vis[1])) |-> ctl.setMask[BIT_LCHG]); // R4
  AST_OSC_CHG: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !$stable(vis[0])) |-> ctl.setMask[BIT_OCHG]); // R5
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    fullStopEntry |=> !vis[0]); // R8
  AST_WARM_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !warm |-> !(ctl.setMask[BIT_LCHG] || ctl.setMask[BIT_OCHG])); // R11

endmodule

// File: rtl/clkrst_flag_dp.sv
module clkrst_flag_dp
  import clkrst_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             porRstN,
  input  flagCtl_t         ctl,
  input  logic             tmrIrqEn,
  input  logic             lockIrqEn,
  input  logic             oscIrqEn,
  output logic [REG_W-1:0] rdData,
  output logic             tmrIrq,
  output logic             lockIrq,
  output logic             oscIrq
);

  logic [REG_W-1:0] regQ;

  for (genvar i = 0; i < REG_W; i++) begin : gBit
    if (i == BIT_POR) begin : gPor
      logic bitQ;
      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN) bitQ <= 1'b1;
        else          bitQ <= ctl.setMask[i] | (bitQ & ~ctl.clrMask[i]);
      end
      assign regQ[i] = bitQ;

      AST_POR_KEEP: assert property (@(posedge clk) disable iff (!porRstN)
        (bitQ && !ctl.clrMask[i]) |=> bitQ); // R12
    end else if (FLAG_MASK[i]) begin : gFlag
      logic bitQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bitQ <= 1'b0;
        else       bitQ <= ctl.setMask[i] | (bitQ & ~ctl.clrMask[i]);
      end
      assign regQ[i] = bitQ;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
        ctl.setMask[i] |=> bitQ); // R10
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        (bitQ && !ctl.clrMask[i]) |=> bitQ); // R2
    end else if (i == BIT_LOCK) begin : gLock
      assign regQ[i] = ctl.lockLvl;
    end else begin : gOsc
      assign regQ[i] = ctl.oscLvl;
    end
  end

  assign rdData  = regQ;
  assign tmrIrq  = regQ[BIT_TMR]  & tmrIrqEn;
  assign lockIrq = regQ[BIT_LCHG] & lockIrqEn;
  assign oscIrq  = regQ[BIT_OCHG] & oscIrqEn;

endmodule

// File: rtl/clkrst_status_reg.sv
module clkrst_status_reg
  import clkrst_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             tmrTick,
  input  logic             lvrEvt,
  input  logic             ilaEvt,
  input  logic             lockIn,
  input  logic             oscIn,
  input  logic             fullStopEntry,
  input  logic             tmrIrqEn,
  input  logic             lockIrqEn,
  input  logic             oscIrqEn,
  output logic             tmrIrq,
  output logic             lockIrq,
  output logic             oscIrq
);

  logic     sysRstN;
  flagCtl_t ctl;

  assign sysRstN = porRstN & rstN;

  clkrst_flag_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk           (clk),
    .rstN          (sysRstN),
    .wrEn          (wrEn),
    .wrData        (wrData),
    .tmrTick       (tmrTick),
    .lvrEvt        (lvrEvt),
    .ilaEvt        (ilaEvt),
    .lockIn        (lockIn),
    .oscIn         (oscIn),
    .fullStopEntry (fullStopEntry),
    .ctl           (ctl)
  );

  clkrst_flag_dp u_dp (
    .clk       (clk),
    .rstN      (sysRstN),
    .porRstN   (porRstN),
    .ctl       (ctl),
    .tmrIrqEn  (tmrIrqEn),
    .lockIrqEn (lockIrqEn),
    .oscIrqEn  (oscIrqEn),
    .rdData    (rdData),
    .tmrIrq    (tmrIrq),
    .lockIrq   (lockIrq),
    .oscIrq    (oscIrq)
  );

endmodule

// File: tb/test_clkrst_status_reg.sv
`timescale 1ns/1ps
module test_clkrst_status_reg;

  logic       clk = 1'b0;
  logic       porRstN, rstN, wrEn;
  logic [7:0] wrData, rdData;
  logic       tmrTick, lvrEvt, ilaEvt, lockIn, oscIn, fullStopEntry;
  logic       tmrIrqEn, lockIrqEn, oscIrqEn, tmrIrq, lockIrq, oscIrq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  clkrst_status_reg i_clkrst_status_reg (
    .clk(clk), .porRstN(porRstN), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .tmrTick(tmrTick), .lvrEvt(lvrEvt), .ilaEvt(ilaEvt),
    .lockIn(lockIn), .oscIn(oscIn), .fullStopEntry(fullStopEntry),
    .tmrIrqEn(tmrIrqEn), .lockIrqEn(lockIrqEn), .oscIrqEn(oscIrqEn),
    .tmrIrq(tmrIrq), .lockIrq(lockIrq), .oscIrq(oscIrq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    tick(1);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic tResetState();
    chk("R1 reset value", rdData, 8'h40);
    chk("R1 irqs idle", {5'b0, tmrIrq, lockIrq, oscIrq}, 8'h00);
  endtask

  task automatic tPorKeep();
    wr(8'h00);
    chk("R2 write zero keeps flag", rdData, 8'h40);
    rstN = 1'b0; tick(1); rstN = 1'b1; tick(4);
    chk("R12 system reset keeps por flag", rdData, 8'h40);
    wr(8'h40);
    chk("R2 write one clears por flag", rdData, 8'h00);
    porRstN = 1'b0; tick(1); porRstN = 1'b1; tick(4);
    chk("R12 power-on reset sets flag", rdData, 8'h40);
    wr(8'h40);
  endtask

  task automatic tTimer();
    tmrTick = 1'b1; tick(1); tmrTick = 1'b0;
    chk("R6 timer flag set", rdData, 8'h80);
    chk("R6 timer irq enabled", {7'b0, tmrIrq}, 8'h01);
    tmrIrqEn = 1'b0; #1;
    chk("R6 timer irq masked", {7'b0, tmrIrq}, 8'h00);
    tmrIrqEn = 1'b1;
    wr(8'h80);
    chk("R2 timer flag cleared", rdData, 8'h00);
  endtask

  task automatic tResetEvents();
    lvrEvt = 1'b1; tick(1); lvrEvt = 1'b0;
    chk("R9 low-voltage flag", rdData, 8'h20);
    ilaEvt = 1'b1; tick(1); ilaEvt = 1'b0;
    chk("R9 illegal-address flag", rdData, 8'h24);
    wr(8'h20);
    chk("R2 selective clear", rdData, 8'h04);
    wr(8'h04);
    chk("R2 second clear", rdData, 8'h00);
  endtask

  task automatic tLock();
    lockIn = 1'b1; tick(2);
    chk("R4 lock status before flag", rdData, 8'h08);
    tick(1);
    chk("R4 lock rise flag", rdData, 8'h18);
    chk("R7 lock irq", {7'b0, lockIrq}, 8'h01);
    wr(8'h10);
    lockIn = 1'b0; tick(3);
    chk("R4 lock fall flag", rdData, 8'h10);
    lockIrqEn = 1'b0; #1;
    chk("R7 lock irq masked", {7'b0, lockIrq}, 8'h00);
    lockIrqEn = 1'b1;
    wr(8'h10);
  endtask

  task automatic tOsc();
    oscIn = 1'b1; tick(2);
    chk("R5 osc status before flag", rdData, 8'h01);
    tick(1);
    chk("R5 osc rise flag", rdData, 8'h03);
    chk("R7 osc irq", {7'b0, oscIrq}, 8'h01);
    wr(8'h02);
    oscIn = 1'b0; tick(3);
    chk("R5 osc fall flag", rdData, 8'h02);
    oscIrqEn = 1'b0; #1;
    chk("R7 osc irq masked", {7'b0, oscIrq}, 8'h00);
    oscIrqEn = 1'b1;
    wr(8'h02);
    chk("R5 osc cleared", rdData, 8'h00);
  endtask

  task automatic tStatusRo();
    lockIn = 1'b1; oscIn = 1'b1; tick(3);
    wr(8'h12);
    chk("R3 status shown", rdData, 8'h09);
    wr(8'hFF);
    chk("R3 write ones ignored", rdData, 8'h09);
    wr(8'h00);
    chk("R3 write zeros ignored", rdData, 8'h09);
  endtask

  task automatic tNoFalseFlag();
    rstN = 1'b0; tick(1); rstN = 1'b1; tick(6);
    chk("R11 no change flag after reset", rdData, 8'h09);
  endtask

  task automatic tFullStop();
    fullStopEntry = 1'b1; tick(1); fullStopEntry = 1'b0;
    chk("R8 osc forced low", rdData, 8'h08);
    tick(1);
    chk("R8 forced drop sets change flag", rdData, 8'h0A);
    wr(8'h02);
    tick(5);
    chk("R8 held low while input high", rdData, 8'h08);
    oscIn = 1'b0; tick(3);
    chk("R8 input low no extra flag", rdData, 8'h08);
    oscIn = 1'b1; tick(3);
    chk("R8 osc status returns", rdData, 8'h0B);
    wr(8'h02);
  endtask

  task automatic tSetWins();
    tmrTick = 1'b1; tick(1); tmrTick = 1'b0;
    chk("R6 timer flag before overlap", rdData, 8'h89);
    tmrTick = 1'b1; wrEn = 1'b1; wrData = 8'h80;
    tick(1);
    tmrTick = 1'b0; wrEn = 1'b0; wrData = 8'h00;
    chk("R10 set wins over clear", rdData, 8'h89);
    wr(8'h80);
    chk("R10 plain clear afterwards", rdData, 8'h09);
  endtask

  initial begin
    porRstN = 1'b0; rstN = 1'b0; wrEn = 1'b0; wrData = 8'h00;
    tmrTick = 1'b0; lvrEvt = 1'b0; ilaEvt = 1'b0; lockIn = 1'b0; oscIn = 1'b0;
    fullStopEntry = 1'b0; tmrIrqEn = 1'b1; lockIrqEn = 1'b1; oscIrqEn = 1'b1;
    tick(2);
    porRstN = 1'b1; rstN = 1'b1;
    tick(4);
    tResetState();
    tPorKeep();
    tTimer();
    tResetEvents();
    tLock();
    tOsc();
    tStatusRo();
    tNoFalseFlag();
    tFullStop();
    tSetWins();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule